// File: doc/BRIEF.md
# General-Purpose Timer with Reference Compare and Input Capture

This block is a counting timer for a microcontroller-class subsystem. A 16-bit counter advances on a prescaled tick taken from one of several clock sources. It compares its value against a programmable reference, and it can either run freely or restart after a match. A capture input latches the count on a chosen edge of an external signal. A small event register records compare hits and captures, and it drives a level interrupt. A timer output pin either toggles on each hit or drops low for one prescaled period.

Software reaches five registers through a flat, single-cycle register port: mode, reference, counter, capture and event. Writes take effect on the clock edge on which `reg_wr` is sampled high. Reads return the addressed register combinationally. The output pin is driven by a three-state machine. In `OUT_HIGH` the pin is high. In `OUT_LOW` the pin is held low in toggle mode. In `OUT_PULSE` the pin is low for one prescaled period in pulse mode. The transitions are as follows:
- `OUT_HIGH` goes to `OUT_LOW` on a hit in toggle mode, and to `OUT_PULSE` on a hit in pulse mode.
- `OUT_LOW` goes back to `OUT_HIGH` on a hit, or when toggle mode is switched off.
- `OUT_PULSE` goes back to `OUT_HIGH` on the next counter tick that carries no hit, and stays in `OUT_PULSE` on a tick that carries one.
- Every state goes to `OUT_HIGH` when the timer is disabled.

Top module: `gpt_timer`

## Requirements
- R1: After reset the mode, counter, capture and event registers read 0, the reference reads 0xFFFF, `tout` is high and `irq` is low. Register addresses are: 0 mode, 1 reference, 2 counter, 3 capture, 4 event.
- R2: While mode bit 0 (run) is clear, the counter is held at 0 and ignores writes, no event bit is set, and `tout` stays high.
- R3: Clock-source field mode[2:1] = 01 selects the system clock. The counter then advances once every (P+1) clocks, where P is mode[15:8].
- R4: Source 10 selects the system clock divided by 16. The counter then advances once every 16*(P+1) clocks.
- R5: Source 11 counts rising edges of `ext_clk_pin`, prescaled by P+1. Source 00 stops counting while the timer remains enabled.
- R6: Event bit 1 is set on the tick that brings the counter to the reference value.
- R7: With mode bit 3 set (restart), the counter returns to 0 on the tick after it reached the reference.
- R8: With mode bit 3 clear, the counter passes the reference and wraps from 0xFFFF to 0.
- R9: Capture-edge field mode[7:6] selects 01 rising, 10 falling, 11 both edges of `cap_pin`, or 00 no capture. On a selected edge the counter is copied to the capture register and event bit 0 is set. Other edges change neither register.
- R10: A write to the event register clears each bit written as 1 and leaves the other bits unchanged.
- R11: `irq` is high exactly when (event bit 1 and mode bit 4) or (event bit 0 and mode[7:6] != 00).
- R12: On a reference hit, with mode bit 5 set, `tout` toggles. With bit 5 clear, `tout` goes low for one prescaled period, one clock when P = 0.
- R13: A counter write loads the written value. A write to the capture register has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the addressed register |
| cap_pin | input | 1 | Capture input, sampled once before edge detection |
| ext_clk_pin | input | 1 | External count clock, sampled once before edge detection |
| tout | output | 1 | Timer output pin |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: CNT_W = 16 and SLOW_DIV = 16. The full 16-bit wrap is brought within a few cycles by loading the counter near 0xFFFF rather than counting up to it. The slow source and the prescaler are measured over exact multiples of their period, which makes each result independent of the divider phase. Capture tests stop the counter with source 00 so that every captured value is exact.

// File: rtl/gpt_pkg.sv
`timescale 1ns/1ps
package gpt_pkg;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_SYS  = 2'b01,
        SRC_SLOW = 2'b10,
        SRC_PIN  = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'b00,
        CAP_RISE = 2'b01,
        CAP_FALL = 2'b10,
        CAP_BOTH = 2'b11
    } cap_edge_e;

    typedef enum logic [1:0] {
        OUT_HIGH  = 2'b00,
        OUT_LOW   = 2'b01,
        OUT_PULSE = 2'b10
    } out_state_e;

    typedef struct packed {
        logic [7:0] prescale;
        cap_edge_e  cap_sel;
        logic       toggle;
        logic       ref_irq_en;
        logic       restart;
        clk_src_e   src;
        logic       run;
    } mode_t;

    localparam logic [2:0] A_MODE  = 3'd0;
    localparam logic [2:0] A_REF   = 3'd1;
    localparam logic [2:0] A_COUNT = 3'd2;
    localparam logic [2:0] A_CAPT  = 3'd3;
    localparam logic [2:0] A_EVENT = 3'd4;

endpackage

// File: rtl/gpt_tick_gen.sv
`timescale 1ns/1ps
module gpt_tick_gen
    import gpt_pkg::*;
#(
    parameter int SLOW_DIV = 16,
    parameter int PS_W     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  clk_src_e        src,
    input  logic [PS_W-1:0] prescale,
    input  logic            pin_rise,
    output logic            cnt_tick
);
    localparam int DIV_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [PS_W-1:0]  ps_q;
    logic             src_tick;
    logic             ps_done;

    always_comb begin
        unique case (src)
            SRC_OFF:  src_tick = 1'b0;
            SRC_SYS:  src_tick = 1'b1;
            SRC_SLOW: src_tick = (div_q == DIV_LAST);
            SRC_PIN:  src_tick = pin_rise;
            default:  src_tick = 1'b0;
        endcase
    end

    assign ps_done  = (ps_q >= prescale);
    assign cnt_tick = run && src_tick && ps_done;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            ps_q  <= '0;
        end else begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
            if (src_tick) begin
                ps_q <= ps_done ? '0 : ps_q + 1'b1;
            end
        end
    end

    // R3: after a counter tick the prescaler starts a fresh period
    p_prescale_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |=> (ps_q == '0));

    // R4: the divided source never ticks on two consecutive clocks
    p_slow_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && src == SRC_SLOW && $stable(src)) |=> !(cnt_tick && src == SRC_SLOW));

endmodule

// File: rtl/gpt_counter.sv
`timescale 1ns/1ps
module gpt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ref_hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        if (restart && cnt_q == ref_val) begin
            nxt = '0;
        end else begin
            nxt = cnt_q + 1'b1;
        end
    end

    assign ref_hit = run && tick && !load && (nxt == ref_val);
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= nxt;
        end
    end

    // R2: a stopped timer holds the count at zero
    p_off_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

    // R7: in restart mode a tick at the reference returns the count to zero
    p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && restart && cnt_q == ref_val) |=> (cnt_q == '0));

    // R8: outside a restart, a tick adds exactly one, wrapping at the top
    p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && !restart) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/gpt_outpin.sv
`timescale 1ns/1ps
module gpt_outpin
    import gpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic toggle_mode,
    input  logic hit,
    input  logic tick,
    output logic tout
);
    out_state_e state_q;
    out_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = OUT_HIGH;
        end else begin
            unique case (state_q)
                OUT_HIGH: begin
                    if (hit) begin
                        state_d = toggle_mode ? OUT_LOW : OUT_PULSE;
                    end
                end
                OUT_LOW: begin
                    if (hit || !toggle_mode) begin
                        state_d = OUT_HIGH;
                    end
                end
                OUT_PULSE: begin
                    if (tick && !hit) begin
                        state_d = OUT_HIGH;
                    end
                end
                default: state_d = OUT_HIGH;
            endcase
        end
    end

    always_comb begin
        tout = (state_q != OUT_LOW) && (state_q != OUT_PULSE);
    end

    // R12: in toggle mode every hit inverts the pin
    p_toggle_flip_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (run && toggle_mode && hit && state_q != OUT_PULSE) |=> (tout != $past(tout)));

    // R12: a pulse ends on the first tick without a hit
    p_pulse_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OUT_PULSE && tick && !hit) |=> tout);

endmodule

// File: rtl/gpt_timer.sv
`timescale 1ns/1ps
module gpt_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SLOW_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             cap_pin,
    input  logic             ext_clk_pin,
    output logic             tout,
    output logic             irq
);
    localparam int PS_W = 8;
    localparam int EV_W = 2;

    mode_t            mode_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] capt_q;
    logic [EV_W-1:0]  ev_q;
    logic [EV_W-1:0]  ev_d;

    logic cap_s, cap_prev, ext_s, ext_prev;
    logic cap_rise, cap_fall, ext_rise;
    logic cap_fire;
    logic cnt_tick, ref_hit;
    logic [CNT_W-1:0] cnt;

    logic wr_mode, wr_ref, wr_count, wr_event;
    assign wr_mode  = reg_wr && (reg_addr == A_MODE);
    assign wr_ref   = reg_wr && (reg_addr == A_REF);
    assign wr_count = reg_wr && (reg_addr == A_COUNT);
    assign wr_event = reg_wr && (reg_addr == A_EVENT);

    // single sampling stage plus previous value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_s    <= 1'b0;
            cap_prev <= 1'b0;
            ext_s    <= 1'b0;
            ext_prev <= 1'b0;
        end else begin
            cap_s    <= cap_pin;
            cap_prev <= cap_s;
            ext_s    <= ext_clk_pin;
            ext_prev <= ext_s;
        end
    end

    assign cap_rise = cap_s && !cap_prev;
    assign cap_fall = !cap_s && cap_prev;
    assign ext_rise = ext_s && !ext_prev;

    always_comb begin
        unique case (mode_q.cap_sel)
            CAP_OFF:  cap_fire = 1'b0;
            CAP_RISE: cap_fire = cap_rise;
            CAP_FALL: cap_fire = cap_fall;
            CAP_BOTH: cap_fire = cap_rise || cap_fall;
            default:  cap_fire = 1'b0;
        endcase
        cap_fire = cap_fire && mode_q.run;
    end

    gpt_tick_gen #(
        .SLOW_DIV (SLOW_DIV),
        .PS_W     (PS_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mode_q.run),
        .src      (mode_q.src),
        .prescale (mode_q.prescale),
        .pin_rise (ext_rise),
        .cnt_tick (cnt_tick)
    );

    gpt_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mode_q.run),
        .tick     (cnt_tick),
        .restart  (mode_q.restart),
        .ref_val  (ref_q),
        .load     (wr_count),
        .load_val (reg_wdata),
        .cnt      (cnt),
        .ref_hit  (ref_hit)
    );

    gpt_outpin u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (mode_q.run),
        .toggle_mode (mode_q.toggle),
        .hit         (ref_hit),
        .tick        (cnt_tick),
        .tout        (tout)
    );

    // event bits: write-one-to-clear, a new event in the same cycle wins
    always_comb begin
        ev_d = ev_q;
        if (wr_event) begin
            ev_d = ev_d & ~reg_wdata[EV_W-1:0];
        end
        if (ref_hit) begin
            ev_d[1] = 1'b1;
        end
        if (cap_fire) begin
            ev_d[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ref_q  <= '1;
            capt_q <= '0;
            ev_q   <= '0;
        end else begin
            if (wr_mode) begin
                mode_q <= mode_t'(reg_wdata[15:0]);
            end
            if (wr_ref) begin
                ref_q <= reg_wdata;
            end
            if (cap_fire) begin
                capt_q <= cnt;
            end
            ev_q <= ev_d;
        end
    end

    assign irq = (ev_q[1] && mode_q.ref_irq_en) ||
                 (ev_q[0] && (mode_q.cap_sel != CAP_OFF));

    always_comb begin
        unique case (reg_addr)
            A_MODE:  reg_rdata = CNT_W'(mode_q);
            A_REF:   reg_rdata = ref_q;
            A_COUNT: reg_rdata = cnt;
            A_CAPT:  reg_rdata = capt_q;
            A_EVENT: reg_rdata = CNT_W'(ev_q);
            default: reg_rdata = '0;
        endcase
    end

    // R2: no event is raised while the timer is stopped
    p_no_event_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q.run |=> !($rose(ev_q[1]) || $rose(ev_q[0])));

    // R9: a selected capture edge leaves event bit 0 set
    p_capture_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> ev_q[0]);

    // R10: writing one to bit 1 clears it unless a hit arrives together
    p_clear_bit1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_event && reg_wdata[1] && !ref_hit) |=> !ev_q[1]);

    // R6: a reference hit is recorded on the following cycle
    p_hit_recorded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_hit |=> ev_q[1]);

endmodule

// File: tb/test_gpt_timer.sv
`timescale 1ns/1ps
module test_gpt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        cap_pin = 1'b0;
    logic        ext_clk_pin = 1'b0;
    logic        tout;
    logic        irq;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    gpt_timer i_gpt_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cap_pin     (cap_pin),
        .ext_clk_pin (ext_clk_pin),
        .tout        (tout),
        .irq         (irq)
    );

    localparam logic [2:0] MODE = 3'd0, REFR = 3'd1, CNTR = 3'd2, CAPR = 3'd3, EVTR = 3'd4;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(MODE, v); chk("R1 mode", v, 16'h0000);
        rd(REFR, v); chk("R1 ref", v, 16'hFFFF);
        rd(CNTR, v); chk("R1 count", v, 16'h0000);
        rd(CAPR, v); chk("R1 capture", v, 16'h0000);
        rd(EVTR, v); chk("R1 event", v, 16'h0000);
        chk("R1 tout", {15'd0, tout}, 16'd1);
        chk("R1 irq", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_disabled;
        logic [15:0] v;
        wr(REFR, 16'h0003);
        wr(MODE, 16'h0002);
        wait_cyc(20);
        rd(CNTR, v); chk("R2 count held", v, 16'h0000);
        wr(CNTR, 16'h0077);
        rd(CNTR, v); chk("R2 write ignored", v, 16'h0000);
        rd(EVTR, v); chk("R2 no event", v, 16'h0000);
        chk("R2 tout high", {15'd0, tout}, 16'd1);
        wr(REFR, 16'hFFFF);
    endtask

    task automatic t_sysclk;
        logic [15:0] a, b;
        wr(MODE, 16'h0003);
        rd(CNTR, a); wait_cyc(10); rd(CNTR, b);
        chk("R3 P=0 rate", b - a, 16'd10);
        wr(MODE, 16'h0303);
        rd(CNTR, a); wait_cyc(40); rd(CNTR, b);
        chk("R3 P=3 rate", b - a, 16'd10);
    endtask

    task automatic t_slow;
        logic [15:0] a, b;
        wr(MODE, 16'h0005);
        rd(CNTR, a); wait_cyc(160); rd(CNTR, b);
        chk("R4 div16 rate", b - a, 16'd10);
        wr(MODE, 16'h0105);
        rd(CNTR, a); wait_cyc(320); rd(CNTR, b);
        chk("R4 div16 P=1 rate", b - a, 16'd10);
    endtask

    task automatic t_pin;
        logic [15:0] a, b;
        wr(MODE, 16'h0007);
        wait_cyc(2);
        rd(CNTR, a);
        for (int i = 0; i < 5; i++) begin
            ext_clk_pin = 1'b1; wait_cyc(2);
            ext_clk_pin = 1'b0; wait_cyc(2);
        end
        wait_cyc(4);
        rd(CNTR, b);
        chk("R5 pin edges", b - a, 16'd5);
        wr(MODE, 16'h0001);
        rd(CNTR, a);
        for (int i = 0; i < 5; i++) begin
            ext_clk_pin = 1'b1; wait_cyc(2);
            ext_clk_pin = 1'b0; wait_cyc(2);
        end
        wait_cyc(30);
        rd(CNTR, b);
        chk("R5 source off", b - a, 16'd0);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        wr(MODE, 16'h0003);
        wr(EVTR, 16'h0003);
        wr(CNTR, 16'hFFFC);
        rd(CNTR, v); chk("R13 count load", v, 16'hFFFC);
        rd(EVTR, v); chk("R6 no hit yet", v, 16'h0000);
        wait_cyc(6);
        rd(CNTR, v); chk("R8 wrap", v, 16'h0002);
        rd(EVTR, v); chk("R6 hit at FFFF", v & 16'h2, 16'h0002);
    endtask

    task automatic t_restart;
        logic [15:0] v;
        wr(REFR, 16'h0005);
        wr(MODE, 16'h000B);
        wr(CNTR, 16'h0003);
        wr(EVTR, 16'h0003);
        rd(CNTR, v); chk("R7 count 4", v, 16'h0004);
        rd(EVTR, v); chk("R6 before hit", v & 16'h2, 16'h0000);
        wait_cyc(1);
        rd(CNTR, v); chk("R7 at ref", v, 16'h0005);
        rd(EVTR, v); chk("R6 hit set", v & 16'h2, 16'h0002);
        wait_cyc(1);
        rd(CNTR, v); chk("R7 back to zero", v, 16'h0000);
        wait_cyc(6);
        rd(CNTR, v); chk("R7 period six", v, 16'h0000);
        wr(MODE, 16'h0003);
        wr(CNTR, 16'h0003);
        wait_cyc(3);
        rd(CNTR, v); chk("R8 runs past ref", v, 16'h0006);
    endtask

    task automatic t_capture;
        logic [15:0] v;
        wr(MODE, 16'h0041);
        wr(EVTR, 16'h0003);
        wr(CNTR, 16'h1234);
        cap_pin = 1'b1; wait_cyc(3);
        rd(CAPR, v); chk("R9 rising capture", v, 16'h1234);
        rd(EVTR, v); chk("R9 capture event", v, 16'h0001);
        wr(REFR, 16'h1236);
        wr(MODE, 16'h0043);
        wait_cyc(2);
        rd(CNTR, v); chk("R6 count at ref", v, 16'h1236);
        wr(MODE, 16'h0041);
        rd(EVTR, v); chk("R6 both events", v, 16'h0003);
        wr(EVTR, 16'h0002);
        rd(EVTR, v); chk("R10 clear bit1 only", v, 16'h0001);
        wr(EVTR, 16'h0001);
        rd(EVTR, v); chk("R10 clear bit0", v, 16'h0000);
        cap_pin = 1'b0; wait_cyc(3);
        rd(EVTR, v); chk("R9 fall ignored in rise mode", v, 16'h0000);
        wr(MODE, 16'h0081);
        wr(CNTR, 16'h5555);
        cap_pin = 1'b1; wait_cyc(3);
        rd(EVTR, v); chk("R9 rise ignored in fall mode", v, 16'h0000);
        rd(CAPR, v); chk("R9 capture kept", v, 16'h1234);
        cap_pin = 1'b0; wait_cyc(3);
        rd(CAPR, v); chk("R9 falling capture", v, 16'h5555);
        rd(EVTR, v); chk("R9 falling event", v, 16'h0001);
        wr(MODE, 16'h0001);
        wr(EVTR, 16'h0001);
        wr(CNTR, 16'h6666);
        cap_pin = 1'b1; wait_cyc(3);
        cap_pin = 1'b0; wait_cyc(3);
        rd(EVTR, v); chk("R9 capture off no event", v, 16'h0000);
        rd(CAPR, v); chk("R9 capture off keeps value", v, 16'h5555);
        wr(MODE, 16'h00C1);
        wr(CNTR, 16'h7777);
        cap_pin = 1'b1; wait_cyc(3);
        rd(CAPR, v); chk("R9 both, rise", v, 16'h7777);
        wr(EVTR, 16'h0001);
        wr(CNTR, 16'h1111);
        cap_pin = 1'b0; wait_cyc(3);
        rd(CAPR, v); chk("R9 both, fall", v, 16'h1111);
        rd(EVTR, v); chk("R9 both event", v, 16'h0001);
        chk("R11 capture irq", {15'd0, irq}, 16'd1);
        wr(CAPR, 16'hBEEF);
        rd(CAPR, v); chk("R13 capture write ignored", v, 16'h1111);
        wr(MODE, 16'h0001);
        chk("R11 irq off when capture off", {15'd0, irq}, 16'd0);
        rd(EVTR, v); chk("R11 event still set", v, 16'h0001);
        wr(EVTR, 16'h0001);
    endtask

    task automatic t_irq;
        logic [15:0] v;
        wr(REFR, 16'h0005);
        wr(MODE, 16'h000B);
        wr(CNTR, 16'h0003);
        wr(EVTR, 16'h0003);
        wait_cyc(1);
        rd(EVTR, v); chk("R6 hit for irq", v, 16'h0002);
        chk("R11 ref irq disabled", {15'd0, irq}, 16'd0);
        wr(MODE, 16'h0011);
        chk("R11 ref irq enabled", {15'd0, irq}, 16'd1);
        wr(EVTR, 16'h0002);
        chk("R11 irq after clear", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_output;
        logic t0;
        int lows;
        wr(REFR, 16'h0005);
        wr(MODE, 16'h002B);
        wait_cyc(8);
        t0 = tout;
        wait_cyc(6);
        chk("R12 toggle once", {15'd0, tout}, {15'd0, ~t0});
        wait_cyc(6);
        chk("R12 toggle back", {15'd0, tout}, {15'd0, t0});
        wr(MODE, 16'h000B);
        wait_cyc(12);
        lows = 0;
        for (int i = 0; i < 60; i++) begin
            wait_cyc(1);
            if (!tout) lows++;
        end
        chk("R12 pulse low cycles", 16'(lows), 16'd10);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_disabled();
        t_sysclk();
        t_slow();
        t_pin();
        t_wrap();
        t_restart();
        t_capture();
        t_irq();
        t_output();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule